// File: doc/BRIEF.md
# Access Burst Merger

The block sits in front of a bus master that prefers long transfers, and folds a stream of word-aligned read byte addresses into burst descriptors. Each descriptor carries a start address, a length in accesses and a kind: incrementing, where every address is four bytes past the one before, or fixed, where every access targets the same address. A burst's kind is decided by the second access that joins it. After that the kind is locked, and only accesses of that kind can extend the burst.

Addresses arrive on a valid/ready port that has an end-of-input flag. Descriptors leave on a registered valid/ready port. The maximum burst length and the enable for fixed merging are set by configuration inputs. A burst is closed in three cases: the next address cannot extend it, it has reached the maximum length, or the beat flagged as the last one has been absorbed. Issuing the bursts on a bus and returning data are left to other blocks.

Top module: `burst_merger`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When fixed merging cannot apply, an accepted address equal to the open burst's base plus four times its length extends it. This holds while the burst has length 1 or is incrementing.
- R3: With `cfg_fixed_en` = 1, an accepted address equal to the open burst's base extends it as a fixed burst. This holds while the burst has length 1 or is fixed.
- R4: Once a burst holds two or more accesses, its kind is locked. An address that would only match the other kind closes the burst and opens a new one.
- R5: A burst opened by an address that extends nothing starts at that address with length 1 and kind incrementing. The burst it displaces is emitted first.
- R6: `cfg_max_len` must lie in 1..256. It is 9 bits wide, so 256 is written 9'h100. A burst that reaches this length is emitted at once, and every emitted length lies in 1..`cfg_max_len`.
- R7: With `cfg_fixed_en` = 0, repeated addresses never merge, and only incrementing bursts form.
- R8: After a beat with `in_last` = 1 is absorbed, no burst stays open. When that beat opens a new burst, the block emits two descriptors back to back: the displaced burst first, then the new one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the descriptor outputs hold their values. `in_ready` is also 0 while a second descriptor from R8 is still waiting to be emitted.
- R10: `out_fixed` is 1 for a fixed burst and 0 for an incrementing burst. A fixed descriptor always has length 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_len | input | 9 | Maximum burst length, 1..256 |
| cfg_fixed_en | input | 1 | Enables merging of same-address accesses |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Address beat accepted when high with valid |
| in_addr | input | 32 | Word-aligned read byte address |
| in_last | input | 1 | Marks the final beat of the input sequence |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer accepts the descriptor |
| out_base | output | 32 | Burst start address |
| out_len | output | 9 | Burst length in accesses |
| out_fixed | output | 1 | 1 = fixed burst, 0 = incrementing |

## Verification
The assertions rely on two things about the inputs. `cfg_max_len` stays within 1..256 whenever a beat is offered. Neither configuration input changes while a burst is open, because the length bound on the open burst is measured against the current setting. The stimulus meets both conditions. It changes configuration only between groups of beats, and every group ends with a beat flagged last, so no burst is open at that point. It also offers only word-aligned addresses, and it holds `out_ready` low only in a dedicated stall test.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic {
    BK_INCR  = 1'b0,
    BK_FIXED = 1'b1
  } burst_kind_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/bm_match.sv
module bm_match
  import bm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 9
) (
  input  logic [AW-1:0] cand_addr,
  input  logic [AW-1:0] open_base,
  input  logic [LW-1:0] open_len,
  input  burst_kind_e   open_kind,
  input  logic          fixed_en,
  output logic          hit_fixed,
  output logic          hit_incr
);
  logic [AW-1:0] stride_addr;
  logic          single;

  always_comb begin
    stride_addr = open_base + (AW'(open_len) << WORD_SHIFT);
    single      = (open_len == LW'(1));
    hit_fixed   = fixed_en && (cand_addr == open_base) &&
                  (single || (open_kind == BK_FIXED));
    hit_incr    = (cand_addr == stride_addr) &&
                  (single || (open_kind == BK_INCR));
  end
endmodule

// File: rtl/bm_track.sv
module bm_track
  import bm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          slot_free,
  input  logic [AW-1:0] in_addr,
  input  logic          in_last,
  input  logic [LW-1:0] cfg_max_len,
  input  logic          cfg_fixed_en,
  output logic          emit,
  output logic [AW-1:0] emit_base,
  output logic [LW-1:0] emit_len,
  output burst_kind_e   emit_kind,
  output logic          flush_pend
);
  logic          open_q, open_d;
  logic          flush_q, flush_d;
  logic [AW-1:0] base_q, base_d;
  logic [LW-1:0] len_q, len_d;
  burst_kind_e   kind_q, kind_d;
  logic          hit_fixed, hit_incr;
  logic [LW-1:0] len_up;
  burst_kind_e   kind_up;
  logic          upd_en;

  bm_match #(.AW(AW), .LW(LW)) u_match (
    .cand_addr (in_addr),
    .open_base (base_q),
    .open_len  (len_q),
    .open_kind (kind_q),
    .fixed_en  (cfg_fixed_en),
    .hit_fixed (hit_fixed),
    .hit_incr  (hit_incr)
  );

  always_comb begin
    len_up    = len_q + LW'(1);
    kind_up   = hit_fixed ? BK_FIXED : BK_INCR;
    open_d    = open_q;
    flush_d   = flush_q;
    base_d    = base_q;
    len_d     = len_q;
    kind_d    = kind_q;
    emit      = 1'b0;
    emit_base = base_q;
    emit_len  = len_q;
    emit_kind = kind_q;
    upd_en    = 1'b0;
    if (flush_q && slot_free) begin
      upd_en  = 1'b1;
      emit    = 1'b1;
      open_d  = 1'b0;
      flush_d = 1'b0;
    end else if (accept) begin
      upd_en = 1'b1;
      if (!open_q) begin
        base_d = in_addr;
        len_d  = LW'(1);
        kind_d = BK_INCR;
        if (in_last || (cfg_max_len == LW'(1))) begin
          emit      = 1'b1;
          emit_base = in_addr;
          emit_len  = LW'(1);
          emit_kind = BK_INCR;
          open_d    = 1'b0;
        end else begin
          open_d = 1'b1;
        end
      end else if (hit_fixed || hit_incr) begin
        len_d  = len_up;
        kind_d = kind_up;
        if (in_last || (len_up == cfg_max_len)) begin
          emit      = 1'b1;
          emit_len  = len_up;
          emit_kind = kind_up;
          open_d    = 1'b0;
        end
      end else begin
        emit   = 1'b1;
        base_d = in_addr;
        len_d  = LW'(1);
        kind_d = BK_INCR;
        open_d = 1'b1;
        if (in_last || (cfg_max_len == LW'(1))) begin
          flush_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      flush_q <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      kind_q  <= BK_INCR;
    end else if (upd_en) begin
      open_q  <= open_d;
      flush_q <= flush_d;
      base_q  <= base_d;
      len_q   <= len_d;
      kind_q  <= kind_d;
    end
  end

  assign flush_pend = flush_q;

  AST_OPEN_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (len_q < cfg_max_len)); // R6
  AST_FLUSH_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> open_q); // R8
  AST_FIXED_TWO_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && (kind_q == BK_FIXED)) |-> (len_q >= LW'(2))); // R4
  AST_EMIT_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> slot_free); // R9
endmodule

// File: rtl/bm_slot.sv
module bm_slot
  import bm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic [LW-1:0] load_len,
  input  burst_kind_e   load_kind,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_base,
  output logic [LW-1:0] out_len,
  output logic          out_fixed,
  output logic          slot_free
);
  logic          vld_q, vld_d;
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic          fix_q;

  always_comb begin
    slot_free = !vld_q || out_ready;
    vld_d     = load ? 1'b1 : (out_ready ? 1'b0 : vld_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      fix_q  <= 1'b0;
    end else if (load) begin
      base_q <= load_base;
      len_q  <= load_len;
      fix_q  <= (load_kind == BK_FIXED);
    end
  end

  assign out_valid = vld_q;
  assign out_base  = base_q;
  assign out_len   = len_q;
  assign out_fixed = fix_q;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(base_q) && $stable(len_q) && $stable(fix_q))); // R9
  AST_FIXED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && fix_q) |-> (len_q >= LW'(2))); // R10
endmodule

// File: rtl/burst_merger.sv
module burst_merger
  import bm_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned MAX_LEN = 256,
  localparam int unsigned LW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_max_len,
  input  logic          cfg_fixed_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_base,
  output logic [LW-1:0] out_len,
  output logic          out_fixed
);
  logic          rst_meta_q, rst_sync_q;
  logic          slot_free, flush_pend, accept, emit;
  logic [AW-1:0] emit_base;
  logic [LW-1:0] emit_len;
  burst_kind_e   emit_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign in_ready = slot_free && !flush_pend;
  assign accept   = in_valid && in_ready;

  bm_track #(.AW(AW), .LW(LW)) u_track (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .accept       (accept),
    .slot_free    (slot_free),
    .in_addr      (in_addr),
    .in_last      (in_last),
    .cfg_max_len  (cfg_max_len),
    .cfg_fixed_en (cfg_fixed_en),
    .emit         (emit),
    .emit_base    (emit_base),
    .emit_len     (emit_len),
    .emit_kind    (emit_kind),
    .flush_pend   (flush_pend)
  );

  bm_slot #(.AW(AW), .LW(LW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (emit),
    .load_base (emit_base),
    .load_len  (emit_len),
    .load_kind (emit_kind),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_base  (out_base),
    .out_len   (out_len),
    .out_fixed (out_fixed),
    .slot_free (slot_free)
  );

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_valid |-> ((out_len != '0) && (out_len <= cfg_max_len))); // R6
  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    in_valid |-> ((cfg_max_len != '0) && (cfg_max_len <= LW'(MAX_LEN)))); // R6
endmodule

// File: tb/sim_burst_merger.sv
module sim_burst_merger;
  localparam int CLK_PERIOD = 10;
  localparam int NSTIM = 24;
  localparam int NEXP  = 15;
  localparam int NGRP  = 6;

  // {grp[3:0], fixed_en, max_len[8:0], last, addr[31:0]}
  localparam logic [46:0] STIM [NSTIM] = '{
    {4'd0, 1'b1, 9'h100, 1'b0, 32'h0000_0000},
    {4'd0, 1'b1, 9'h100, 1'b0, 32'h0000_0004},
    {4'd0, 1'b1, 9'h100, 1'b0, 32'h0000_0010},
    {4'd0, 1'b1, 9'h100, 1'b0, 32'h0000_0014},
    {4'd0, 1'b1, 9'h100, 1'b0, 32'h0000_0020},
    {4'd0, 1'b1, 9'h100, 1'b1, 32'h0000_0020},
    {4'd1, 1'b1, 9'h100, 1'b0, 32'h0000_0100},
    {4'd1, 1'b1, 9'h100, 1'b0, 32'h0000_0100},
    {4'd1, 1'b1, 9'h100, 1'b1, 32'h0000_0104},
    {4'd1, 1'b1, 9'h100, 1'b0, 32'h0000_0200},
    {4'd1, 1'b1, 9'h100, 1'b0, 32'h0000_0204},
    {4'd1, 1'b1, 9'h100, 1'b1, 32'h0000_0200},
    {4'd2, 1'b0, 9'h100, 1'b0, 32'h0000_0040},
    {4'd2, 1'b0, 9'h100, 1'b0, 32'h0000_0040},
    {4'd2, 1'b0, 9'h100, 1'b1, 32'h0000_0044},
    {4'd3, 1'b1, 9'd3,   1'b0, 32'h0000_0000},
    {4'd3, 1'b1, 9'd3,   1'b0, 32'h0000_0004},
    {4'd3, 1'b1, 9'd3,   1'b0, 32'h0000_0008},
    {4'd3, 1'b1, 9'd3,   1'b0, 32'h0000_000C},
    {4'd3, 1'b1, 9'd3,   1'b1, 32'h0000_0010},
    {4'd4, 1'b1, 9'd1,   1'b0, 32'h0000_0008},
    {4'd4, 1'b1, 9'd1,   1'b1, 32'h0000_0008},
    {4'd5, 1'b1, 9'h100, 1'b1, 32'h0000_0050},
    {4'd5, 1'b1, 9'h100, 1'b1, 32'h0000_0054}
  };

  // {grp[3:0], fixed, len[8:0], base[31:0]}
  localparam logic [45:0] EXP [NEXP] = '{
    {4'd0, 1'b0, 9'd2, 32'h0000_0000},
    {4'd0, 1'b0, 9'd2, 32'h0000_0010},
    {4'd0, 1'b1, 9'd2, 32'h0000_0020},
    {4'd1, 1'b1, 9'd2, 32'h0000_0100},
    {4'd1, 1'b0, 9'd1, 32'h0000_0104},
    {4'd1, 1'b0, 9'd2, 32'h0000_0200},
    {4'd1, 1'b0, 9'd1, 32'h0000_0200},
    {4'd2, 1'b0, 9'd1, 32'h0000_0040},
    {4'd2, 1'b0, 9'd2, 32'h0000_0040},
    {4'd3, 1'b0, 9'd3, 32'h0000_0000},
    {4'd3, 1'b0, 9'd2, 32'h0000_000C},
    {4'd4, 1'b0, 9'd1, 32'h0000_0008},
    {4'd4, 1'b0, 9'd1, 32'h0000_0008},
    {4'd5, 1'b0, 9'd1, 32'h0000_0050},
    {4'd5, 1'b0, 9'd1, 32'h0000_0054}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_max_len = 9'h100;
  logic        cfg_fixed_en = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_base;
  logic [8:0]  out_len;
  logic        out_fixed;

  int n_chk = 0;
  int n_bad = 0;
  int got_n = 0;
  logic [41:0] got [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_merger u0 (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len), .cfg_fixed_en(cfg_fixed_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
    .out_len(out_len), .out_fixed(out_fixed)
  );

  always @(negedge clk) begin
    #3;
    if (rst_n && out_valid && out_ready && got_n < 32) begin
      got[got_n] = {out_fixed, out_len, out_base};
      got_n = got_n + 1;
    end
  end

  function automatic string grp_tag(input int g);
    case (g)
      0: grp_tag = "R2/R3/R5/R10";
      1: grp_tag = "R4/R5/R8";
      2: grp_tag = "R7";
      3: grp_tag = "R6";
      4: grp_tag = "R6/R8";
      default: grp_tag = "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic l);
    @(negedge clk); #1;
    in_valid = 1'b1; in_addr = a; in_last = l;
    #1;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

    for (int g = 0; g < NGRP; g++) begin
      int k;
      got_n = 0;
      for (int i = 0; i < NSTIM; i++) begin
        if (int'(STIM[i][46:43]) == g) begin
          cfg_fixed_en = STIM[i][42];
          cfg_max_len  = STIM[i][41:33];
          send(STIM[i][31:0], STIM[i][32]);
        end
      end
      repeat (8) @(negedge clk);
      k = 0;
      for (int e = 0; e < NEXP; e++) begin
        if (int'(EXP[e][45:42]) == g) begin
          check(k < got_n && got[k] == EXP[e][41:0], grp_tag(g),
                64'(got[k]), 64'(EXP[e][41:0]));
          k++;
        end
      end
      check(got_n == k, {grp_tag(g), " count"}, 64'(got_n), 64'(k));
    end

    // R9 stall: descriptor held while consumer not ready
    got_n = 0;
    cfg_fixed_en = 1'b1; cfg_max_len = 9'h100;
    @(negedge clk); #1 out_ready = 1'b0;
    send(32'h300, 1'b1);
    @(negedge clk); #2;
    check(out_valid && out_base == 32'h300 && out_len == 9'd1, "R9 held desc",
          64'({out_valid, out_len, out_base}), 64'({1'b1, 9'd1, 32'h300}));
    in_valid = 1'b1; in_addr = 32'h400; in_last = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 in_ready low", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    #2;
    check(out_base == 32'h300 && in_ready == 1'b0, "R9 stable", 64'(out_base), 64'h300);
    out_ready = 1'b1;
    @(negedge clk); #1 in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(got_n == 2, "R9 count", 64'(got_n), 64'd2);
    check(got[0] == {1'b0, 9'd1, 32'h300}, "R9 first", 64'(got[0]), 64'({1'b0, 9'd1, 32'h300}));
    check(got[1] == {1'b0, 9'd1, 32'h400}, "R9 second", 64'(got[1]), 64'({1'b0, 9'd1, 32'h400}));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule